// File: doc/BRIEF.md
# SD Card SPI-Mode Initialization Sequencer

This block takes an SD card from power-up to the ready state of its SPI compatibility mode, so that block reads can follow. It runs on the system clock and never shifts bits itself. It hands whole bytes to a byte-wide SPI shifter through a request/acknowledge port, and it owns the card's chip-select line. A single `start` pulse runs the full ritual. First it waits for the supply to settle. Then it sends wake-up clocks with the card deselected, resets the card, checks the interface condition, and polls the application init command until the card leaves idle.

The run ends in one of two terminal states. In the ready state `done` is high and `fast_clk` asks the shifter for its high bit rate. In the failure state `error` is high and `err_code` names the step that failed. In both states `last_r1` holds the most recent one-byte card response. A new `start` from either terminal state, or from idle, runs the whole sequence again.

The FSM states are: idle, power-up wait, wake, command, response poll, echo read, gap, ready and fail. The transitions are:
- idle, ready or fail go to power-up wait on `start`.
- Power-up wait goes to wake when its timer expires.
- Wake goes to command after the last wake byte.
- Command goes to response poll after the sixth frame byte.
- Response poll goes to gap, echo read, ready or fail, depending on the response byte and the command.
- Echo read goes to gap or fail after its fourth byte.
- Gap goes to command after one filler byte.

Top module: `sdspi_boot_seq`

## Requirements
- R1: When `start` is sampled high while not busy, `busy` rises on the next cycle. `xfer_req` then stays low for exactly POWERUP_CYCLES cycles before the first byte request.
- R2: The first WAKE_BYTES transferred bytes are all 0xFF, with `cs_n` high.
- R3: Command frames are sent with `cs_n` low, six bytes each. The reset frame is 40 00 00 00 00 95 and the interface-condition frame is 48 00 00 01 AA 87. The app-prefix frame is 77 00 00 00 00 65 and the init frame is 69 40 00 00 00 77. The order is reset, interface-condition, then app-prefix/init pairs.
- R4: After each frame the block sends 0xFF bytes with `cs_n` low, up to NCR_LIMIT of them. The first received byte with bit 7 clear is the response and is copied to `last_r1`. If none arrives, the run fails with code 1. `last_r1` reads 0xFF after reset and after each `start`.
- R5: A reset-frame response other than 0x01 fails the run with code 2.
- R6: An interface-condition response other than 0x01 fails with code 3. Otherwise four more bytes are read. The low nibble of the third must be 0x1 and the fourth must be 0xAA, or the run fails with code 4.
- R7: An app-prefix response with any of bits 7..1 set fails with code 5. An init response of 0x00 ends in ready. A response of 0x01 repeats the app-prefix/init pair. Any other init response fails with code 5.
- R8: At most MAX_RETRY init frames are sent per run. If the MAX_RETRY-th init response is still 0x01, the run fails with code 6.
- R9: Between consecutive frames exactly one 0xFF byte is sent with `cs_n` high. No filler follows the last frame of a run.
- R10: `fast_clk` is low whenever a byte is transferred during a run. In ready, `done` and `fast_clk` are high and `cs_n` is high. In fail, `error` is high, `err_code` is non-zero and `cs_n` is high. `err_code` is 0 whenever `error` is low. These outputs hold until the next `start`.
- R11: `xfer_req` stays high with `xfer_tx` and `cs_n` unchanged until `xfer_ack` is sampled high. `xfer_rx` is taken in the acknowledge cycle, and each acknowledge completes one byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an initialization run |
| busy | output | 1 | Run in progress |
| done | output | 1 | Card ready, held until next start |
| error | output | 1 | Run failed, held until next start |
| err_code | output | 3 | Failure cause (1..6), 0 when no failure |
| last_r1 | output | 8 | Most recent one-byte card response |
| cs_n | output | 1 | Card chip select, active low |
| fast_clk | output | 1 | Request high SPI bit rate |
| xfer_req | output | 1 | Byte transfer request to the shifter |
| xfer_tx | output | 8 | Byte to send |
| xfer_ack | input | 1 | Shifter completed the byte |
| xfer_rx | input | 8 | Byte received during the transfer |

## Verification
The bench builds the block with a 40-cycle power-up wait, ten wake bytes, a poll limit of 8 and a retry cap of 5. These values make a silent card, the last allowed poll byte and the retry timeout reachable within a few hundred bytes. A behavioural card model replies with a varied number of leading filler bytes and a random acknowledge latency. Each run also varies the card's busy count and the injected faulty responses, so every failure code and both sides of each limit occur, including back-to-back runs without reset.

// File: rtl/sdspi_boot_pkg.sv
package sdspi_boot_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PWRWAIT,
        ST_WAKE,
        ST_CMD,
        ST_POLL,
        ST_ECHO,
        ST_GAP,
        ST_READY,
        ST_FAIL
    } boot_state_t;

    typedef enum logic [1:0] {
        CMD_RESET,
        CMD_IFCOND,
        CMD_APPPFX,
        CMD_OPINIT
    } boot_cmd_t;

    localparam logic [2:0] ERR_NONE    = 3'd0;
    localparam logic [2:0] ERR_NORESP  = 3'd1;
    localparam logic [2:0] ERR_RESET   = 3'd2;
    localparam logic [2:0] ERR_IFCOND  = 3'd3;
    localparam logic [2:0] ERR_ECHO    = 3'd4;
    localparam logic [2:0] ERR_APP     = 3'd5;
    localparam logic [2:0] ERR_TIMEOUT = 3'd6;

    localparam int FRAME_BYTES = 6;

endpackage

// File: rtl/sdspi_counter.sv
module sdspi_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (inc)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/sdspi_frame_bytes.sv
module sdspi_frame_bytes
    import sdspi_boot_pkg::*;
(
    input  boot_cmd_t   cmd,
    input  logic [2:0]  idx,
    output logic [7:0]  data
);
    logic [7:0] lead, arg3, arg2, arg1, arg0, tail;

    always_comb begin
        unique case (cmd)
            CMD_RESET:  {lead, arg3, arg2, arg1, arg0, tail} = 48'h40_00_00_00_00_95;
            CMD_IFCOND: {lead, arg3, arg2, arg1, arg0, tail} = 48'h48_00_00_01_AA_87;
            CMD_APPPFX: {lead, arg3, arg2, arg1, arg0, tail} = 48'h77_00_00_00_00_65;
            CMD_OPINIT: {lead, arg3, arg2, arg1, arg0, tail} = 48'h69_40_00_00_00_77;
            default:    {lead, arg3, arg2, arg1, arg0, tail} = '1;
        endcase
        unique case (idx)
            3'd0:    data = lead;
            3'd1:    data = arg3;
            3'd2:    data = arg2;
            3'd3:    data = arg1;
            3'd4:    data = arg0;
            default: data = tail;
        endcase
    end
endmodule

// File: rtl/sdspi_boot_seq.sv
module sdspi_boot_seq
    import sdspi_boot_pkg::*;
#(
    parameter int POWERUP_CYCLES = 50000,
    parameter int WAKE_BYTES     = 10,
    parameter int NCR_LIMIT      = 16,
    parameter int MAX_RETRY      = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output logic       busy,
    output logic       done,
    output logic       error,
    output logic [2:0] err_code,
    output logic [7:0] last_r1,
    output logic       cs_n,
    output logic       fast_clk,
    output logic       xfer_req,
    output logic [7:0] xfer_tx,
    input  logic       xfer_ack,
    input  logic [7:0] xfer_rx
);
    localparam int BYTE_MAX0 = (WAKE_BYTES > NCR_LIMIT) ? WAKE_BYTES : NCR_LIMIT;
    localparam int BYTE_MAX  = (BYTE_MAX0 > FRAME_BYTES) ? BYTE_MAX0 : FRAME_BYTES;
    localparam int BYTE_W    = $clog2(BYTE_MAX + 1);
    localparam int WAIT_W    = $clog2(POWERUP_CYCLES + 1);
    localparam int RETRY_W   = $clog2(MAX_RETRY + 1);

    localparam logic [WAIT_W-1:0]  WAIT_LAST  = WAIT_W'(POWERUP_CYCLES - 1);
    localparam logic [BYTE_W-1:0]  WAKE_LAST  = BYTE_W'(WAKE_BYTES - 1);
    localparam logic [BYTE_W-1:0]  POLL_LAST  = BYTE_W'(NCR_LIMIT - 1);
    localparam logic [BYTE_W-1:0]  FRAME_LAST = BYTE_W'(FRAME_BYTES - 1);
    localparam logic [BYTE_W-1:0]  ECHO_VHS   = BYTE_W'(2);
    localparam logic [BYTE_W-1:0]  ECHO_PAT   = BYTE_W'(3);
    localparam logic [RETRY_W-1:0] RETRY_LAST = RETRY_W'(MAX_RETRY - 1);

    boot_state_t state_q, state_d;
    boot_cmd_t   cmd_q, cmd_d;
    logic [2:0]  err_q, err_d;
    logic [7:0]  r1_q, r1_d;
    logic        echo_ok_q, echo_ok_d;

    logic              wt_clr, wt_inc, bc_clr, bc_inc, rt_clr, rt_inc;
    logic [WAIT_W-1:0]  wait_cnt;
    logic [BYTE_W-1:0]  byte_cnt;
    logic [RETRY_W-1:0] retry_cnt;
    logic [7:0]         frame_byte;
    logic               got;

    sdspi_counter #(.W(WAIT_W)) u_wait (
        .clk(clk), .rst_n(rst_n), .clr(wt_clr), .inc(wt_inc), .count(wait_cnt));
    sdspi_counter #(.W(BYTE_W)) u_bytes (
        .clk(clk), .rst_n(rst_n), .clr(bc_clr), .inc(bc_inc), .count(byte_cnt));
    sdspi_counter #(.W(RETRY_W)) u_retry (
        .clk(clk), .rst_n(rst_n), .clr(rt_clr), .inc(rt_inc), .count(retry_cnt));
    sdspi_frame_bytes u_frame (
        .cmd(cmd_q), .idx(byte_cnt[2:0]), .data(frame_byte));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cmd_q     <= CMD_RESET;
            err_q     <= ERR_NONE;
            r1_q      <= 8'hFF;
            echo_ok_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            cmd_q     <= cmd_d;
            err_q     <= err_d;
            r1_q      <= r1_d;
            echo_ok_q <= echo_ok_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d   = state_q;
        cmd_d     = cmd_q;
        err_d     = err_q;
        r1_d      = r1_q;
        echo_ok_d = echo_ok_q;
        wt_clr = 1'b0; wt_inc = 1'b0;
        bc_clr = 1'b0; bc_inc = 1'b0;
        rt_clr = 1'b0; rt_inc = 1'b0;
        got    = xfer_ack && xfer_req;
        unique case (state_q)
            ST_IDLE, ST_READY, ST_FAIL: begin
                if (start) begin
                    state_d = ST_PWRWAIT;
                    cmd_d   = CMD_RESET;
                    err_d   = ERR_NONE;
                    r1_d    = 8'hFF;
                    wt_clr  = 1'b1;
                    bc_clr  = 1'b1;
                    rt_clr  = 1'b1;
                end
            end
            ST_PWRWAIT: begin
                wt_inc = 1'b1;
                if (wait_cnt == WAIT_LAST) state_d = ST_WAKE;
            end
            ST_WAKE: if (got) begin
                bc_inc = 1'b1;
                if (byte_cnt == WAKE_LAST) begin
                    state_d = ST_CMD;
                    bc_clr  = 1'b1;
                end
            end
            ST_CMD: if (got) begin
                bc_inc = 1'b1;
                if (byte_cnt == FRAME_LAST) begin
                    state_d = ST_POLL;
                    bc_clr  = 1'b1;
                end
            end
            ST_POLL: if (got) begin
                if (!xfer_rx[7]) begin
                    r1_d   = xfer_rx;
                    bc_clr = 1'b1;
                    unique case (cmd_q)
                        CMD_RESET: begin
                            if (xfer_rx == 8'h01) begin state_d = ST_GAP; cmd_d = CMD_IFCOND; end
                            else begin state_d = ST_FAIL; err_d = ERR_RESET; end
                        end
                        CMD_IFCOND: begin
                            if (xfer_rx == 8'h01) begin state_d = ST_ECHO; echo_ok_d = 1'b1; end
                            else begin state_d = ST_FAIL; err_d = ERR_IFCOND; end
                        end
                        CMD_APPPFX: begin
                            if (xfer_rx[7:1] == 7'd0) begin state_d = ST_GAP; cmd_d = CMD_OPINIT; end
                            else begin state_d = ST_FAIL; err_d = ERR_APP; end
                        end
                        CMD_OPINIT: begin
                            if (xfer_rx == 8'h00) state_d = ST_READY;
                            else if (xfer_rx != 8'h01) begin state_d = ST_FAIL; err_d = ERR_APP; end
                            else if (retry_cnt == RETRY_LAST) begin state_d = ST_FAIL; err_d = ERR_TIMEOUT; end
                            else begin state_d = ST_GAP; cmd_d = CMD_APPPFX; rt_inc = 1'b1; end
                        end
                        default: state_d = ST_FAIL;
                    endcase
                end else if (byte_cnt == POLL_LAST) begin
                    state_d = ST_FAIL;
                    err_d   = ERR_NORESP;
                end else begin
                    bc_inc = 1'b1;
                end
            end
            ST_ECHO: if (got) begin
                bc_inc = 1'b1;
                if (byte_cnt == ECHO_VHS && xfer_rx[3:0] != 4'h1) echo_ok_d = 1'b0;
                if (byte_cnt == ECHO_PAT) begin
                    bc_clr = 1'b1;
                    if (echo_ok_q && xfer_rx == 8'hAA) begin state_d = ST_GAP; cmd_d = CMD_APPPFX; end
                    else begin state_d = ST_FAIL; err_d = ERR_ECHO; end
                end
            end
            ST_GAP: if (got) begin
                state_d = ST_CMD;
                bc_clr  = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        busy     = !(state_q inside {ST_IDLE, ST_READY, ST_FAIL});
        done     = (state_q == ST_READY);
        error    = (state_q == ST_FAIL);
        fast_clk = (state_q == ST_READY);
        err_code = err_q;
        last_r1  = r1_q;
        xfer_req = state_q inside {ST_WAKE, ST_CMD, ST_POLL, ST_ECHO, ST_GAP};
        cs_n     = !(state_q inside {ST_CMD, ST_POLL, ST_ECHO});
        xfer_tx  = (state_q == ST_CMD) ? frame_byte : 8'hFF;
    end
endmodule

// File: rtl/sdspi_boot_seq_chk.sv
module sdspi_boot_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       error,
    input logic [2:0] err_code,
    input logic       cs_n,
    input logic       fast_clk,
    input logic       xfer_req,
    input logic [7:0] xfer_tx,
    input logic       xfer_ack
);
    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !xfer_req)); // R1

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_tx) && $stable(cs_n))); // R11

    AST_CS_LOW_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> xfer_req); // R3

    AST_FAST_READY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        fast_clk |-> (done && cs_n && !xfer_req)); // R10

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!xfer_req && cs_n)); // R10

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, done, error})); // R10

    AST_CODE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        error == (err_code != 3'd0)); // R10
endmodule

bind sdspi_boot_seq sdspi_boot_seq_chk u_chk (.*);

// File: tb/sdspi_boot_seq_test.sv
module sdspi_boot_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int P_WAIT  = 40;
    localparam int P_WAKE  = 10;
    localparam int P_NCR   = 8;
    localparam int P_RETRY = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       busy, done, error, cs_n, fast_clk, xfer_req;
    logic [2:0] err_code;
    logic [7:0] last_r1, xfer_tx;
    logic       xfer_ack = 1'b0;
    logic [7:0] xfer_rx = 8'hFF;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdspi_boot_seq #(
        .POWERUP_CYCLES(P_WAIT), .WAKE_BYTES(P_WAKE),
        .NCR_LIMIT(P_NCR), .MAX_RETRY(P_RETRY)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .error(error), .err_code(err_code), .last_r1(last_r1), .cs_n(cs_n),
        .fast_clk(fast_clk), .xfer_req(xfer_req), .xfer_tx(xfer_tx),
        .xfer_ack(xfer_ack), .xfer_rx(xfer_rx)
    );

    // Card knobs (driven by the stimulus only)
    int         k_ncr = 0, k_busy = 0;
    logic [7:0] k_r0 = 8'h01, k_r8 = 8'h01, k_vhs = 8'h01, k_pat = 8'hAA;
    logic [7:0] k_app = 8'h01, k_fin = 8'h00;

    // Card model state (driven by the card process only)
    logic [7:0] q [0:31];
    int q_len, q_rd, cmd_cnt, frames, frame_bad, wake_cnt, wake_bad;
    int gaps, gap_bad, acmd, fast_bad, stable_bad, pre_cnt, total;
    int lat;
    logic       waiting, seen_low, held_cs;
    logic [7:0] held_tx;
    logic [7:0] fbuf [0:5];

    int errors = 0, checks = 0;

    function automatic logic [7:0] frame_of(input logic [7:0] lead, input int idx);
        logic [47:0] f;
        case (lead)
            8'h40:   f = 48'h40_00_00_00_00_95;
            8'h48:   f = 48'h48_00_00_01_AA_87;
            8'h77:   f = 48'h77_00_00_00_00_65;
            default: f = 48'h69_40_00_00_00_77;
        endcase
        return f[47 - 8*idx -: 8];
    endfunction

    function automatic logic [7:0] lead_of(input int k);
        if (k == 0) return 8'h40;
        if (k == 1) return 8'h48;
        return (k % 2 == 0) ? 8'h77 : 8'h69;
    endfunction

    task automatic push(input logic [7:0] b);
        q[q_rd + q_len] = b;
        q_len++;
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            xfer_ack = 1'b0;
            waiting = 1'b0;
        end else if (start) begin
            q_len = 0; q_rd = 0; cmd_cnt = 0; frames = 0; frame_bad = 0;
            wake_cnt = 0; wake_bad = 0; gaps = 0; gap_bad = 0; acmd = 0;
            fast_bad = 0; stable_bad = 0; pre_cnt = 0; total = 0;
            waiting = 1'b0; seen_low = 1'b0;
        end else if (xfer_ack) begin
            xfer_ack = 1'b0;
        end else if (xfer_req) begin
            if (!waiting) begin
                waiting = 1'b1;
                lat = int'($urandom % 4);
                held_tx = xfer_tx;
                held_cs = cs_n;
            end else if (xfer_tx != held_tx || cs_n != held_cs) begin
                stable_bad++;
            end
            if (lat == 0) begin
                waiting = 1'b0;
                total++;
                if (fast_clk) fast_bad++;
                xfer_rx = 8'hFF;
                if (cs_n) begin
                    q_len = 0; q_rd = 0; cmd_cnt = 0;
                    if (!seen_low) begin
                        wake_cnt++;
                        if (xfer_tx != 8'hFF) wake_bad++;
                    end else begin
                        gaps++;
                        if (xfer_tx != 8'hFF) gap_bad++;
                    end
                end else begin
                    seen_low = 1'b1;
                    if (q_len > 0) begin
                        xfer_rx = q[q_rd];
                        q_rd++; q_len--;
                    end
                    if (cmd_cnt > 0 || xfer_tx[7:6] == 2'b01) begin
                        fbuf[cmd_cnt] = xfer_tx;
                        cmd_cnt++;
                        if (cmd_cnt == 6) begin
                            cmd_cnt = 0;
                            for (int i = 0; i < 6; i++)
                                if (fbuf[i] != frame_of(lead_of(frames), i)) frame_bad++;
                            frames++;
                            q_len = 0; q_rd = 0;
                            for (int i = 0; i < k_ncr; i++) push(8'hFF);
                            case (fbuf[0])
                                8'h40: push(k_r0);
                                8'h48: begin
                                    push(k_r8); push(8'h00); push(8'h00);
                                    push(k_vhs); push(k_pat);
                                end
                                8'h77: push(k_app);
                                default: begin
                                    acmd++;
                                    push((acmd <= k_busy) ? 8'h01 : k_fin);
                                end
                            endcase
                        end
                    end
                end
                xfer_ack = 1'b1;
            end else begin
                lat--;
            end
        end else if (busy && total == 0) begin
            pre_cnt++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected outcome computed from the requirements
    task automatic expect_run(output int e_err, output int e_r1,
                              output int e_frames, output int e_acmd);
        e_acmd = 0;
        if (k_ncr >= P_NCR) begin e_err = 1; e_r1 = 8'hFF; e_frames = 1; return; end
        e_frames = 1;
        if (k_r0 != 8'h01) begin e_err = 2; e_r1 = k_r0; return; end
        e_frames = 2;
        if (k_r8 != 8'h01) begin e_err = 3; e_r1 = k_r8; return; end
        if (k_vhs[3:0] != 4'h1 || k_pat != 8'hAA) begin e_err = 4; e_r1 = 8'h01; return; end
        for (int i = 1; i <= P_RETRY; i++) begin
            logic [7:0] r;
            e_frames++;
            if (k_app[7:1] != 7'd0) begin e_err = 5; e_r1 = k_app; return; end
            e_frames++;
            e_acmd = i;
            r = (i <= k_busy) ? 8'h01 : k_fin;
            if (r == 8'h00) begin e_err = 0; e_r1 = 0; return; end
            if (r != 8'h01) begin e_err = 5; e_r1 = r; return; end
        end
        e_err = 6; e_r1 = 8'h01;
    endtask

    task automatic run(input string tag);
        int e_err, e_r1, e_frames, e_acmd, n;
        expect_run(e_err, e_r1, e_frames, e_acmd);
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        n = 0;
        do begin @(negedge clk); n++; end while (!(done || error) && n < 20000);
        @(negedge clk);
        if (n >= 20000) begin
            errors++; checks++;
            $display("FAIL R10 %s: run did not finish actual busy expected done/error", tag);
        end
        chk({"R1 pre-wait ", tag}, pre_cnt, P_WAIT);
        chk({"R2 wake count ", tag}, wake_cnt, P_WAKE);
        chk({"R2 wake bytes ", tag}, wake_bad, 0);
        chk({"R3 frame count ", tag}, frames, e_frames);
        chk({"R3 frame bytes ", tag}, frame_bad, 0);
        chk({"R4 last_r1 ", tag}, int'(last_r1), e_r1);
        chk({"R5-code err_code ", tag}, int'(err_code), e_err);
        chk({"R8 init frames ", tag}, acmd, e_acmd);
        chk({"R9 gap count ", tag}, gaps, e_frames - 1);
        chk({"R9 gap bytes ", tag}, gap_bad, 0);
        chk({"R10 done ", tag}, int'(done), (e_err == 0) ? 1 : 0);
        chk({"R10 error ", tag}, int'(error), (e_err != 0) ? 1 : 0);
        chk({"R10 fast ", tag}, int'(fast_clk), (e_err == 0) ? 1 : 0);
        chk({"R10 fast during run ", tag}, fast_bad, 0);
        chk({"R10 cs_n ", tag}, int'(cs_n), 1);
        chk({"R11 request hold ", tag}, stable_bad, 0);
    endtask

    task automatic nominal();
        k_ncr = 1; k_busy = 2; k_r0 = 8'h01; k_r8 = 8'h01;
        k_vhs = 8'h01; k_pat = 8'hAA; k_app = 8'h01; k_fin = 8'h00;
    endtask

    function automatic logic [7:0] bad_r1();
        logic [7:0] v;
        v = 8'($urandom) & 8'h7F;
        if (v < 8'h02) v = 8'h04;
        return v;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #1;
        chk("R10 reset busy", int'(busy), 0);
        chk("R10 reset done", int'(done), 0);
        chk("R10 reset error", int'(error), 0);
        chk("R10 reset cs_n", int'(cs_n), 1);
        chk("R10 reset fast", int'(fast_clk), 0);
        chk("R11 reset req", int'(xfer_req), 0);
        chk("R4 reset last_r1", int'(last_r1), 8'hFF);
        rst_n = 1'b1;

        nominal();                  run("R7 nominal");
        nominal(); k_ncr = 0; k_busy = 0; run("R7 instant ready");
        nominal(); k_ncr = P_NCR - 1; run("R4 last poll byte");
        nominal(); k_ncr = P_NCR;     run("R4 no response");
        nominal(); k_r0 = 8'h00;      run("R5 reset answer 00");
        nominal(); k_r8 = 8'h05;      run("R6 illegal ifcond");
        nominal(); k_pat = 8'hA5;     run("R6 bad pattern");
        nominal(); k_vhs = 8'h02;     run("R6 bad voltage");
        nominal(); k_app = 8'h04;     run("R7 bad app prefix");
        nominal(); k_fin = 8'h40;     run("R7 bad init answer");
        nominal(); k_busy = P_RETRY - 1; run("R8 ready on last try");
        nominal(); k_busy = P_RETRY;  run("R8 timeout");

        for (int it = 0; it < 24; it++) begin
            int sel;
            nominal();
            k_ncr  = int'($urandom % (P_NCR + 1));
            k_busy = int'($urandom % (P_RETRY + 2));
            k_app  = ($urandom % 2) ? 8'h01 : 8'h00;
            sel = int'($urandom % 8);
            case (sel)
                0: begin k_r0 = 8'($urandom) & 8'h7F; if (k_r0 == 8'h01) k_r0 = 8'h05; end
                1: k_r8 = bad_r1();
                2: k_pat = 8'($urandom);
                3: k_app = bad_r1();
                4: k_fin = bad_r1();
                default: ;
            endcase
            run("R7 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        errors++; checks++;
        $display("FAIL R10 watchdog: actual hung expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule